// File: doc/BRIEF.md
# Raster-Line Interrupt Generator

This block produces the periodic maskable interrupt of a video system. It counts the ends of horizontal sync pulses in a line counter. When the count reaches the programmed period, it raises an active-low interrupt request. The request stays asserted for as long as needed, until the processor runs an interrupt-acknowledge cycle. The block recognises that cycle when the opcode-fetch strobe and the I/O-request strobe are both low.

The acknowledge does two things. It drops the request, and it clears one bit of the line counter. A handler that is serviced late therefore does not push the next interrupt a full period away. It also cannot bring the next interrupt closer than 32 lines.

Vertical sync realigns the counter to the frame. A fixed number of line ends after vertical sync begins, the counter restarts from zero. If the counter had already passed the halfway threshold at that point, a request is raised as well. A software strobe clears both the counter and any pending request.

All inputs are sampled on the system clock and are assumed to be synchronous to it. The video timing that drives the sync inputs is generated elsewhere.

Top module: `rig_raster_irq`

## Requirements
- R1: While reset is active and after it is released, `int_n` is 1 and the line counter is 0.
- R2: A line end is a cycle where `hsync` is sampled 0 after being sampled 1 in the previous cycle. Each line end advances the counter by one. On the line end that would take the counter to 52, the counter becomes 0 and the request is raised. `int_n` goes to 0 at the clock edge that samples that line end.
- R3: Once raised, the request (`int_n` = 0) stays asserted indefinitely until an acknowledge or a software clear.
- R4: An acknowledge is the first cycle in which `m1_n` and `iorq_n` are both sampled 0. It drops the request at that clock edge. Holding both strobes low for further cycles has no additional effect.
- R5: An acknowledge clears bit 5 of the line counter, so a count of 32 or more is reduced by 32. Counts below 32 are unchanged. This happens whether or not a request is pending.
- R6: A cycle where `vsync` is sampled 1 after 0 arms the frame realignment. On the second line end after that cycle, the counter is set to 0 instead of advancing.
- R7: At the realignment line end of R6, the request is raised if the count held just before that line end was 32 or more.
- R8: A cycle with `soft_clr` = 1 sets the counter to 0 and drops the request, overriding every other event in that cycle. It does not disarm a pending realignment.
- R9: When an acknowledge and a line end fall in the same cycle, the bit-5 clear applies first and the advance or realignment then acts on the reduced count. A request raised by that line end survives the acknowledge.
- R10: A new `vsync` rise before the realignment completes restarts the two-line-end delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync | input | 1 | Horizontal sync, active high; its falling edge marks a line end |
| vsync | input | 1 | Vertical sync, active high |
| m1_n | input | 1 | Processor opcode-fetch strobe, active low |
| iorq_n | input | 1 | Processor I/O-request strobe, active low |
| soft_clr | input | 1 | Software strobe clearing counter and request |
| int_n | output | 1 | Interrupt request to the processor, active low |

## Verification
The bench builds the block with its default parameters: a 6-bit counter, a period of 52 lines, acknowledge clearing bit 5, a realignment two line ends after vertical sync, and a threshold of 32. With these values, directed sequences land exactly one line before and on the period and on both sides of the 32-line threshold, both for the acknowledge reduction and for the vertical-sync request. Randomised strobes then overlap acknowledges, line ends, vertical sync rises and software clears in the same cycle, which reaches the precedence rules of R8, R9 and R10.

// File: rtl/rig_pkg.sv
`timescale 1ns/1ps
package rig_pkg;
  // Per-cycle event bundle handed from the edge detectors to the counter.
  typedef struct packed {
    logic hs_fall;   // line end
    logic vs_rise;   // frame start
    logic ack_rise;  // first cycle of acknowledge
    logic clr;       // software clear
  } rig_evt_t;
endpackage

// File: rtl/rig_edge.sv
`timescale 1ns/1ps
module rig_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = din;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = din[i] & ~prev_q[i];
    assign fall[i] = ~din[i] & prev_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/rig_vsync_align.sv
`timescale 1ns/1ps
module rig_vsync_align #(
  parameter int VS_LINES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_rise,
  input  logic hs_fall,
  output logic resync
);
  localparam int VS_W = $clog2(VS_LINES + 1);
  localparam logic [VS_W-1:0] LAST = VS_W'(VS_LINES - 1);

  logic            armed_q, armed_d;
  logic [VS_W-1:0] n_q, n_d;

  assign resync = armed_q & hs_fall & ~vs_rise & (n_q == LAST);

  always_comb begin
    armed_d = armed_q;
    n_d     = n_q;
    if (vs_rise) begin
      armed_d = 1'b1;
      n_d     = '0;
    end else if (armed_q && hs_fall) begin
      if (resync) begin
        armed_d = 1'b0;
        n_d     = '0;
      end else begin
        n_d = n_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      n_q     <= '0;
    end else begin
      armed_q <= armed_d;
      n_q     <= n_d;
    end
  end
endmodule

// File: rtl/rig_line_count.sv
`timescale 1ns/1ps
module rig_line_count
  import rig_pkg::*;
#(
  parameter int LINE_W      = 6,
  parameter int TRIP_COUNT  = 52,
  parameter int ACK_CLR_BIT = 5,
  parameter int LATE_MIN    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rig_evt_t          ev,
  input  logic              resync,
  output logic              req,
  output logic [LINE_W-1:0] count
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(TRIP_COUNT - 1);
  localparam logic [LINE_W-1:0] LATE = LINE_W'(LATE_MIN);

  logic [LINE_W-1:0] cnt_q, cnt_d, base;
  logic              req_q, req_d;

  always_comb begin
    base = cnt_q;
    if (ev.ack_rise) base[ACK_CLR_BIT] = 1'b0;
    cnt_d = base;
    req_d = req_q & ~ev.ack_rise;
    if (ev.clr) begin
      cnt_d = '0;
      req_d = 1'b0;
    end else if (ev.hs_fall) begin
      if (resync) begin
        cnt_d = '0;
        if (base >= LATE) req_d = 1'b1;
      end else if (base == LAST) begin
        cnt_d = '0;
        req_d = 1'b1;
      end else begin
        cnt_d = base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign req   = req_q;
  assign count = cnt_q;
endmodule

// File: rtl/rig_raster_irq.sv
`timescale 1ns/1ps
module rig_raster_irq
  import rig_pkg::*;
#(
  parameter int LINE_W      = 6,
  parameter int TRIP_COUNT  = 52,
  parameter int ACK_CLR_BIT = 5,
  parameter int LATE_MIN    = 32,
  parameter int VS_LINES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic vsync,
  input  logic m1_n,
  input  logic iorq_n,
  input  logic soft_clr,
  output logic int_n
);
  localparam int N_EDGE = 3;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [N_EDGE-1:0] lvl, rise, fall;
  logic              ack_lvl;
  assign ack_lvl = ~m1_n & ~iorq_n;
  assign lvl     = {ack_lvl, vsync, hsync};

  rig_edge #(.W(N_EDGE)) u_edge (
    .clk(clk), .rst_n(rst_core_n), .din(lvl), .rise(rise), .fall(fall)
  );

  logic hs_fall, vs_rise, ack_rise, clr_s, resync, req;
  logic [LINE_W-1:0] line_cnt;
  assign hs_fall  = fall[0];
  assign vs_rise  = rise[1];
  assign ack_rise = rise[2];
  assign clr_s    = soft_clr;

  rig_evt_t ev;
  always_comb begin
    ev.hs_fall  = hs_fall;
    ev.vs_rise  = vs_rise;
    ev.ack_rise = ack_rise;
    ev.clr      = clr_s;
  end

  rig_vsync_align #(.VS_LINES(VS_LINES)) u_vs (
    .clk(clk), .rst_n(rst_core_n), .vs_rise(vs_rise), .hs_fall(hs_fall),
    .resync(resync)
  );

  rig_line_count #(
    .LINE_W(LINE_W), .TRIP_COUNT(TRIP_COUNT),
    .ACK_CLR_BIT(ACK_CLR_BIT), .LATE_MIN(LATE_MIN)
  ) u_cnt (
    .clk(clk), .rst_n(rst_core_n), .ev(ev), .resync(resync),
    .req(req), .count(line_cnt)
  );

  assign int_n = ~req;
endmodule

// File: rtl/rig_raster_irq_chk.sv
`timescale 1ns/1ps
module rig_raster_irq_chk #(
  parameter int LINE_W     = 6,
  parameter int TRIP_COUNT = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_n,
  input logic              hs_fall,
  input logic              ack_rise,
  input logic              clr_s,
  input logic [LINE_W-1:0] line_cnt
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> int_n);

  // R2: count never reaches the period value
  a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
    line_cnt < LINE_W'(TRIP_COUNT));

  // R2: the request is only raised by a line end
  a_r2_raise_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n && $past(int_n) |-> $past(hs_fall));

  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n && !ack_rise && !clr_s |=> !int_n);

  // R4
  a_r4_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rise && !hs_fall |=> int_n);

  // R8
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> int_n && line_cnt == '0);
endmodule

bind rig_raster_irq rig_raster_irq_chk #(.LINE_W(LINE_W), .TRIP_COUNT(TRIP_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .int_n(int_n), .hs_fall(hs_fall),
  .ack_rise(ack_rise), .clr_s(clr_s), .line_cnt(line_cnt)
);

// File: tb/rig_raster_irq_test.sv
`timescale 1ns/1ps
module rig_raster_irq_test;
  logic clk = 1'b0;
  logic rst_n, hsync, vsync, m1_n, iorq_n, soft_clr;
  logic int_n;
  int   vectors = 0;
  int   errors  = 0;
  bit   done    = 0;

  always #4 clk = ~clk;

  rig_raster_irq uut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .m1_n(m1_n), .iorq_n(iorq_n), .soft_clr(soft_clr), .int_n(int_n)
  );

  // Reference state computed from the requirements.
  int m_cnt, m_n;
  bit m_req, m_arm, m_hp, m_vp, m_ap;

  task automatic m_reset();
    m_cnt = 0; m_n = 0; m_req = 0; m_arm = 0; m_hp = 0; m_vp = 0; m_ap = 0;
  endtask

  task automatic m_step(input bit hs, input bit vs, input bit ack, input bit clr);
    bit hf, vr, ar, rs, nreq;
    int base;
    hf = m_hp & ~hs;
    vr = ~m_vp & vs;
    ar = ~m_ap & ack;
    rs = m_arm & hf & ~vr & (m_n == 1);
    if (vr) begin m_arm = 1; m_n = 0; end
    else if (m_arm && hf) begin
      if (rs) begin m_arm = 0; m_n = 0; end
      else m_n = m_n + 1;
    end
    base = ar ? (m_cnt & ~32) : m_cnt;
    nreq = m_req & ~ar;
    if (clr) begin m_cnt = 0; nreq = 0; end
    else if (hf) begin
      if (rs) begin m_cnt = 0; if (base >= 32) nreq = 1; end
      else if (base == 51) begin m_cnt = 0; nreq = 1; end
      else m_cnt = base + 1;
    end else m_cnt = base;
    m_req = nreq;
    m_hp = hs; m_vp = vs; m_ap = ack;
  endtask

  function automatic bit exp_int_n();
    return ~m_req;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: int_n=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: the model follows the sampled inputs, the output is checked at the falling edge.
  task automatic cyc(input bit check_model);
    @(posedge clk);
    m_step(hsync, vsync, ~m1_n & ~iorq_n, soft_clr);
    @(negedge clk);
    if (check_model) chk("R2 R3 R4 R5 R6 R7 R8 R9 R10 model", int_n, exp_int_n());
  endtask

  task automatic hpulse(input int n);
    for (int i = 0; i < n; i++) begin
      hsync = 1; cyc(0);
      hsync = 0; cyc(0);
    end
  endtask

  task automatic ack();
    m1_n = 0; iorq_n = 0; cyc(0);
    m1_n = 1; iorq_n = 1; cyc(0);
  endtask

  task automatic vspulse();
    vsync = 1; cyc(0);
    vsync = 0; cyc(0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: int_n=%b expected run end", int_n);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 0; hsync = 0; vsync = 0; m1_n = 1; iorq_n = 1; soft_clr = 0;
    m_reset();
    repeat (3) @(negedge clk);
    chk("R1 in reset", int_n, 1'b1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release", int_n, 1'b1);

    // R2: period of 52 line ends
    hpulse(51); chk("R2 51 lines", int_n, 1'b1);
    hpulse(1);  chk("R2 52nd line", int_n, 1'b0);
    // R3: held without timeout
    repeat (200) cyc(0);
    chk("R3 held", int_n, 1'b0);
    // R4: acknowledge drops it; holding the strobes low does nothing more
    m1_n = 0; iorq_n = 0; cyc(0);
    chk("R4 ack drop", int_n, 1'b1);
    repeat (5) cyc(0);
    m1_n = 1; iorq_n = 1; cyc(0);

    // R5: count 40, acknowledge -> 8; 43 more lines no request, 44th raises it
    hpulse(40); ack();
    hpulse(43); chk("R5 reduced count, 43 lines", int_n, 1'b1);
    hpulse(1);  chk("R5 reduced count, 44th line", int_n, 1'b0);
    ack();

    // R8: clear restarts the count and drops a pending request
    hpulse(20); soft_clr = 1; cyc(0); soft_clr = 0;
    hpulse(51); chk("R8 cleared count, 51 lines", int_n, 1'b1);
    hpulse(1);  chk("R8 cleared count, 52nd", int_n, 1'b0);
    soft_clr = 1; cyc(0); soft_clr = 0;
    chk("R8 clear drops request", int_n, 1'b1);

    // R6 R7: late count (41) at realignment raises a request
    hpulse(40); vspulse();
    hpulse(1); chk("R6 first line after vsync", int_n, 1'b1);
    hpulse(1); chk("R7 late realign raises", int_n, 1'b0);
    ack();
    hpulse(51); chk("R6 count restarted, 51", int_n, 1'b1);
    hpulse(1);  chk("R6 count restarted, 52", int_n, 1'b0);
    ack();
    // R6 R7: early count (11) realigns silently
    hpulse(10); vspulse(); hpulse(2);
    chk("R7 early realign silent", int_n, 1'b1);
    hpulse(51); chk("R6 early realign, 51", int_n, 1'b1);
    hpulse(1);  chk("R6 early realign, 52", int_n, 1'b0);
    ack();

    // R9: count 51, line end together with acknowledge -> 19+1 = 20, no request
    hpulse(51);
    hsync = 1; cyc(0);
    hsync = 0; m1_n = 0; iorq_n = 0; cyc(0);
    m1_n = 1; iorq_n = 1; cyc(0);
    chk("R9 ack before advance", int_n, 1'b1);
    hpulse(31); chk("R9 count 51", int_n, 1'b1);
    hpulse(1);  chk("R9 wrap", int_n, 1'b0);
    ack();

    // R10: second vsync rise restarts the delay
    hpulse(40); vspulse(); hpulse(1); vspulse(); hpulse(1);
    chk("R10 delay restarted", int_n, 1'b1);
    hpulse(1);
    chk("R10 realign after restart", int_n, 1'b0);
    ack();

    // Random phase against the reference model
    for (int i = 0; i < 20000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      hsync    = (r < 30) ? ~hsync : hsync;
      vsync    = ($urandom_range(0, 199) == 0) ? ~vsync : vsync;
      if ($urandom_range(0, 59) == 0) begin m1_n = 0; iorq_n = 0; end
      else if ($urandom_range(0, 2) == 0) begin m1_n = 1; iorq_n = 1; end
      else if ($urandom_range(0, 9) == 0) begin m1_n = $urandom_range(0, 1); iorq_n = ~m1_n; end
      soft_clr = ($urandom_range(0, 799) == 0);
      cyc(1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule